// File: doc/BRIEF.md
# Single-Wire Slave Transaction Framer

This block runs the slave side of a transaction on a single-wire, pulse-width-coded sensor bus. A line layer in front of it measures each low pulse and hands over one classified symbol per pulse: data zero, data one, start, attention or reset. The framer rebuilds the frame from these symbols. It takes a start, then a header holding a device code, a register number and a direction bit. Next come the data bits, whose count depends on the register. An even-parity bit and an acknowledge bit close the frame.

Toward the register file the block has a plain port: a register address, read data sampled when the header completes, and write data, a write mask and a one-cycle write strobe. Toward the line layer it asks for a bit slot to be stretched into a one by raising `drvEn` and `drvBit` before that slot begins. It drives the data and parity of a read and the acknowledge of a write. A one-cycle `busErr` pulse reports every acknowledge of zero in a frame the block takes part in.

Top module: `swire_txn_framer`

## Requirements
- R1: The header is sent MSB first: a 3-bit device code, a 6-bit register number, then the direction bit (1 = read, 0 = write). The block takes part when the device code equals `strap` + 1.
- R2: Registers 0x00, 0x04 and 0x20 carry 8 data bits and every other register carries 16. The parity and acknowledge slots follow directly after that count.
- R3: On a read, `regRdData` is sampled at the direction bit. In each data slot, MSB first, the block raises `drvEn` with `drvBit` equal to the data bit; an 8-bit register sends bits 7:0. In the parity slot it drives the bit that makes the header, data and parity together even.
- R4: On a write, the block checks even parity over header, data and parity. In the acknowledge slot it raises `drvEn` with `drvBit` = 1 for a good frame and 0 for a bad one.
- R5: `regWrEn` pulses for one cycle after an acknowledge symbol of one that ends a good write. `regAddr` then holds the register number and `regWrData` holds the data, zero-extended for 8-bit registers. No strobe follows an acknowledge of zero.
- R6: `busErr` pulses for one cycle after an acknowledge symbol of zero in a frame the block takes part in. This holds in both directions: a write with bad parity, and a read acknowledged with zero by the master.
- R7: Device code 0 is broadcast. A broadcast read is ignored, with no drive, strobe or error. A broadcast write to register 0x05 strobes with `regWrMask` = 0x0003. A broadcast write to any other register completes with no strobe. A normal write carries mask 0xFFFF.
- R8: A frame with any other device code causes no drive, no strobe and no error.
- R9: A start symbol in the middle of a frame begins a new frame and raises no error.
- R10: A reset symbol abandons the frame. Later data symbols are ignored until the next start.
- R11: Data symbols after the acknowledge slot are ignored. Any wait between symbols is tolerated, with no timeout.
- R12: An attention symbol does not count as a bit and leaves the frame position unchanged.
- R13: Symbol codes on `symKind` are 0 data zero, 1 data one, 2 start, 3 attention, 4 reset. After reset `drvEn`, `regWrEn` and `busErr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| symValid | input | 1 | One-cycle strobe: a classified symbol is present |
| symKind | input | 3 | Symbol code (see R13) |
| strap | input | 2 | Address strap; the device code is this value plus one |
| regAddr | output | 6 | Register number of the current frame |
| regRdData | input | 16 | Read data from the register file for `regAddr` |
| regWrData | output | 16 | Write data, valid with `regWrEn` |
| regWrMask | output | 16 | Bits of the register the write may change |
| regWrEn | output | 1 | One-cycle register write strobe |
| drvEn | output | 1 | The block controls the current bit slot |
| drvBit | output | 1 | Value to place in the slot; 1 asks the line layer to stretch it |
| busErr | output | 1 | One-cycle pulse on an acknowledge of zero |

## Verification
The bench builds the block with its default widths: a 3-bit device code, 6-bit register numbers, 16-bit registers and a 2-bit strap. At these sizes the whole register space can be swept in both directions, covering both frame lengths and the three short registers. Every strap value can be crossed with every device code in both directions, which covers matching, mismatching and broadcast frames. The bench also plays the master and the wired line, and computes frame parity and read data arithmetically. Parity faults, a read acknowledged with zero, mid-frame start and reset, surplus bits, long stalls and attention symbols inside a frame are each exercised directly.

// File: rtl/swf_pkg.sv
package swf_pkg;
  localparam int DEV_W   = 3;
  localparam int REG_W   = 6;
  localparam int DATA_W  = 16;
  localparam int SHORT_W = 8;
  localparam int STRAP_W = 2;
  localparam int HDR_W   = DEV_W + REG_W + 1;
  localparam int MAX_CNT = (DATA_W > HDR_W) ? DATA_W : HDR_W;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  localparam logic [REG_W-1:0]  CTRL_REG   = REG_W'(6'h05);
  localparam logic [DATA_W-1:0] BCAST_MASK = DATA_W'(16'h0003);

  typedef enum logic [2:0] {
    SYM_ZERO  = 3'd0,
    SYM_ONE   = 3'd1,
    SYM_START = 3'd2,
    SYM_ATTN  = 3'd3,
    SYM_RESET = 3'd4
  } sym_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_DATA, ST_PAR, ST_ACK, ST_SKIP
  } state_e;

  typedef struct packed {
    logic clear;
    logic hdrBit;
    logic lastHdr;
    logic dataBit;
    logic parBit;
    logic ackBit;
  } strobe_t;

  function automatic logic isShortReg(input logic [REG_W-1:0] r);
    return (r == REG_W'(6'h00)) || (r == REG_W'(6'h04)) || (r == REG_W'(6'h20));
  endfunction
endpackage

// File: rtl/swf_ctrl.sv
module swf_ctrl
  import swf_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          symValid,
  input  logic [2:0]    symKind,
  input  logic          addrHit,
  input  logic          isShort,
  output state_e        phase,
  output strobe_t       strb
);
  state_e           state, nState;
  logic [CNT_W-1:0] cnt, nCnt;
  logic [CNT_W-1:0] lastIdx;

  assign lastIdx = isShort ? CNT_W'(SHORT_W - 1) : CNT_W'(DATA_W - 1);
  assign phase   = state;

  always_comb begin
    strb   = '0;
    nState = state;
    nCnt   = cnt;
    if (symValid) begin
      case (symKind)
        SYM_RESET: begin
          nState = ST_IDLE;
          nCnt   = '0;
        end
        SYM_START: begin
          nState     = ST_HDR;
          nCnt       = '0;
          strb.clear = 1'b1;
        end
        SYM_ZERO, SYM_ONE: begin
          case (state)
            ST_HDR: begin
              strb.hdrBit = 1'b1;
              if (cnt == CNT_W'(HDR_W - 1)) begin
                strb.lastHdr = 1'b1;
                nState       = addrHit ? ST_DATA : ST_SKIP;
                nCnt         = '0;
              end else begin
                nCnt = cnt + 1'b1;
              end
            end
            ST_DATA: begin
              strb.dataBit = 1'b1;
              if (cnt == lastIdx) begin
                nState = ST_PAR;
                nCnt   = '0;
              end else begin
                nCnt = cnt + 1'b1;
              end
            end
            ST_PAR: begin
              strb.parBit = 1'b1;
              nState      = ST_ACK;
            end
            ST_ACK: begin
              strb.ackBit = 1'b1;
              nState      = ST_SKIP;
            end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nState;
      cnt   <= nCnt;
    end
  end

  // R10: a reset symbol always returns the framer to idle
  p_reset_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    symValid && symKind == SYM_RESET |=> state == ST_IDLE);

  // R9: a start symbol always opens a fresh header
  p_start_hdr_r9: assert property (@(posedge clk) disable iff (!rstN)
    symValid && symKind == SYM_START |=> state == ST_HDR && cnt == '0);

  // R12: attention leaves the frame position untouched
  p_attn_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    symValid && symKind == SYM_ATTN |=> $stable(state) && $stable(cnt));

  // R2: the bit counter never passes the longest field
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(MAX_CNT));
endmodule

// File: rtl/swf_dpath.sv
module swf_dpath
  import swf_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         symKind,
  input  logic [STRAP_W-1:0] strap,
  input  state_e             phase,
  input  strobe_t            strb,
  input  logic [DATA_W-1:0]  regRdData,
  output logic               addrHit,
  output logic               isShort,
  output logic [REG_W-1:0]   regAddr,
  output logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regWrMask,
  output logic               regWrEn,
  output logic               drvEn,
  output logic               drvBit,
  output logic               busErr
);
  localparam int ID_W = DEV_W + REG_W;

  logic [ID_W-1:0]   hdrReg;
  logic [DEV_W-1:0]  devField;
  logic [REG_W-1:0]  regField;
  logic [DEV_W-1:0]  ownDev;
  logic              bitVal, isBcast;
  logic              rwReg, shortReg, parAcc, parOk;
  logic [DATA_W-1:0] sh;

  assign bitVal   = (symKind == SYM_ONE);
  assign devField = hdrReg[ID_W-1:REG_W];
  assign regField = hdrReg[REG_W-1:0];
  assign ownDev   = DEV_W'(strap) + DEV_W'(1);
  assign isBcast  = (devField == '0);
  // the direction bit is the symbol being taken when this is consulted
  assign addrHit  = (devField == ownDev) || (isBcast && !bitVal);
  assign isShort  = shortReg;
  assign regAddr  = regField;

  assign regWrData = shortReg ? DATA_W'(sh[SHORT_W-1:0]) : sh;
  assign regWrMask = isBcast ? BCAST_MASK : '1;

  always_comb begin
    drvEn  = 1'b0;
    drvBit = 1'b0;
    case (phase)
      ST_DATA: begin drvEn = rwReg;  drvBit = sh[DATA_W-1]; end
      ST_PAR:  begin drvEn = rwReg;  drvBit = parAcc;       end
      ST_ACK:  begin drvEn = !rwReg; drvBit = parOk;        end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrReg   <= '0;
      rwReg    <= 1'b0;
      shortReg <= 1'b0;
      parAcc   <= 1'b0;
      parOk    <= 1'b0;
      sh       <= '0;
      regWrEn  <= 1'b0;
      busErr   <= 1'b0;
    end else begin
      regWrEn <= 1'b0;
      busErr  <= 1'b0;
      if (strb.clear) begin
        parAcc <= 1'b0;
        parOk  <= 1'b0;
      end
      if (strb.hdrBit) begin
        parAcc <= parAcc ^ bitVal;
        if (!strb.lastHdr) begin
          hdrReg <= {hdrReg[ID_W-2:0], bitVal};
        end else begin
          rwReg    <= bitVal;
          shortReg <= isShortReg(regField);
          if (bitVal)
            sh <= isShortReg(regField) ? (regRdData << (DATA_W - SHORT_W)) : regRdData;
        end
      end
      if (strb.dataBit) begin
        parAcc <= parAcc ^ bitVal;
        sh     <= {sh[DATA_W-2:0], bitVal};
      end
      if (strb.parBit) begin
        parOk  <= (parAcc == bitVal);
        parAcc <= parAcc ^ bitVal;
      end
      if (strb.ackBit) begin
        if (bitVal && !rwReg && parOk && (!isBcast || regField == CTRL_REG))
          regWrEn <= 1'b1;
        if (!bitVal)
          busErr <= 1'b1;
      end
    end
  end

  // R5, R6: a frame ends in either a write or an error, never both
  p_wr_err_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && busErr));

  // R5: a strobe only follows a write frame whose parity checked good
  p_wr_good_par_r5: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> $past(parOk) && !rwReg);

  // R5: the write strobe lasts a single cycle
  p_wr_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  // R6: the error output lasts a single cycle
  p_err_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    busErr |=> !busErr);

  // R7: a broadcast strobe can only reach the control register
  p_bcast_ctrl_r7: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && isBcast |-> regAddr == CTRL_REG && regWrMask == BCAST_MASK);
endmodule

// File: rtl/swire_txn_framer.sv
module swire_txn_framer
  import swf_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               symValid,
  input  logic [2:0]         symKind,
  input  logic [STRAP_W-1:0] strap,
  output logic [REG_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]  regRdData,
  output logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regWrMask,
  output logic               regWrEn,
  output logic               drvEn,
  output logic               drvBit,
  output logic               busErr
);
  state_e  phase;
  strobe_t strb;
  logic    addrHit, isShort;

  swf_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .symValid (symValid),
    .symKind  (symKind),
    .addrHit  (addrHit),
    .isShort  (isShort),
    .phase    (phase),
    .strb     (strb)
  );

  swf_dpath i_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .symKind   (symKind),
    .strap     (strap),
    .phase     (phase),
    .strb      (strb),
    .regRdData (regRdData),
    .addrHit   (addrHit),
    .isShort   (isShort),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regWrMask (regWrMask),
    .regWrEn   (regWrEn),
    .drvEn     (drvEn),
    .drvBit    (drvBit),
    .busErr    (busErr)
  );

  // R10: after a reset symbol nothing is driven onto the line
  p_reset_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    symValid && symKind == SYM_RESET |=> !drvEn);
endmodule

// File: tb/test_swire_txn_framer.sv
`timescale 1ns/1ps
module test_swire_txn_framer;
  import swf_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        symValid = 1'b0;
  logic [2:0]  symKind = 3'd0;
  logic [1:0]  strap = 2'd2;
  logic [5:0]  regAddr;
  logic [15:0] regRdData, regWrData, regWrMask;
  logic        regWrEn, drvEn, drvBit, busErr;

  always #2 clk = ~clk;

  assign regRdData = {regAddr, 4'h9, ~regAddr};

  swire_txn_framer i_swire_txn_framer (
    .clk(clk), .rstN(rstN), .symValid(symValid), .symKind(symKind), .strap(strap),
    .regAddr(regAddr), .regRdData(regRdData), .regWrData(regWrData),
    .regWrMask(regWrMask), .regWrEn(regWrEn), .drvEn(drvEn), .drvBit(drvBit),
    .busErr(busErr)
  );

  int checks = 0, errors = 0;
  int wrCount = 0, errCount = 0;
  logic [15:0] lastData, lastMask;
  logic [5:0]  lastAddr;

  always @(negedge clk) begin
    if (rstN) begin
      if (regWrEn) begin
        wrCount++;
        lastData = regWrData;
        lastMask = regWrMask;
        lastAddr = regAddr;
      end
      if (busErr) errCount++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic sendSym(input logic [2:0] k);
    symValid = 1'b1;
    symKind  = k;
    @(negedge clk);
    symValid = 1'b0;
    @(negedge clk);
  endtask

  // wired line: a slave stretching a slot turns it into a one
  task automatic sendBit(input bit mb, output bit obs, output bit sd, output bit sb);
    sd  = drvEn;
    sb  = drvBit;
    obs = mb | (sd & sb);
    sendSym(obs ? 3'd1 : 3'd0);
  endtask

  function automatic logic [15:0] rdModel(input logic [5:0] r);
    return {r, 4'h9, ~r};
  endfunction

  function automatic logic [15:0] wrModel(input logic [5:0] r, input int salt);
    return (16'(r) * 16'h0401) ^ 16'hA5C3 ^ 16'(salt);
  endfunction

  task automatic runFrame(input logic [2:0] dev, input logic [5:0] rg, input bit rw,
                          input logic [15:0] wdata, input bit flipPar, input bit masterAck,
                          input int gap, input bit attn, input string req);
    int  len = (rg == 6'h00 || rg == 6'h04 || rg == 6'h20) ? 8 : 16;
    bit  hit = (dev == 3'(strap) + 3'd1) || (dev == 3'd0 && !rw);
    logic [9:0] hdr = {dev, rg, rw};
    logic [15:0] rv = rdModel(rg);
    bit  par = 1'b0, obs, sd, sb, ackObs, expWr, expErr;
    logic [15:0] got = '0;
    int  w0 = wrCount, e0 = errCount;
    sendSym(3'd2);
    for (int i = 0; i < 10; i++) begin
      sendBit(hdr[9-i], obs, sd, sb);
      check(sd == 0, "R1", "drive in header", int'(sd), 0);
      par ^= obs;
    end
    if (gap > 0) repeat (gap) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      bit eb = (len == 8) ? rv[7-i] : rv[15-i];
      if (attn && i == 3) sendSym(3'd3);
      sendBit(rw ? 1'b0 : wdata[len-1-i], obs, sd, sb);
      if (hit && rw) begin
        check(sd == 1, "R3", "read data drive", int'(sd), 1);
        check(obs == eb, "R2", "read data bit", int'(obs), int'(eb));
      end else begin
        check(sd == 0, hit ? "R4" : "R8", "drive in data slot", int'(sd), 0);
      end
      par ^= obs;
      got = {got[14:0], obs};
    end
    if (rw) begin
      sendBit(1'b0, obs, sd, sb);
      check(sd == hit, "R3", "parity slot drive", int'(sd), int'(hit));
      if (hit) check(sb == par, "R3", "read parity bit", int'(sb), int'(par));
    end else begin
      sendBit(par ^ flipPar, obs, sd, sb);
      check(sd == 0, "R4", "parity slot drive", int'(sd), 0);
    end
    if (rw) begin
      sendBit(masterAck, ackObs, sd, sb);
      check(sd == 0, "R3", "ack slot drive on read", int'(sd), 0);
    end else begin
      sendBit(1'b0, ackObs, sd, sb);
      check(sd == hit, "R4", "ack slot drive on write", int'(sd), int'(hit));
      if (hit) check(sb == !flipPar, "R4", "ack value", int'(sb), int'(!flipPar));
    end
    @(negedge clk);
    expWr  = hit && !rw && !flipPar && (dev != 3'd0 || rg == 6'h05);
    expErr = hit && !ackObs;
    check(wrCount - w0 == int'(expWr), req, "write strobes", wrCount - w0, int'(expWr));
    check(errCount - e0 == int'(expErr), "R6", "bus errors", errCount - e0, int'(expErr));
    if (expWr) begin
      logic [15:0] ed = (len == 8) ? {8'h00, wdata[7:0]} : wdata;
      logic [15:0] em = (dev == 3'd0) ? 16'h0003 : 16'hFFFF;
      check(lastAddr == rg, "R5", "write address", int'(lastAddr), int'(rg));
      check(lastData == ed, "R5", "write data", int'(lastData), int'(ed));
      check(lastMask == em, "R7", "write mask", int'(lastMask), int'(em));
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    bit obs, sd, sb;
    int w0, e0;
    repeat (3) @(negedge clk);
    check(drvEn == 0, "R13", "drvEn after reset", int'(drvEn), 0);
    check(regWrEn == 0, "R13", "regWrEn after reset", int'(regWrEn), 0);
    check(busErr == 0, "R13", "busErr after reset", int'(busErr), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 R5: whole register space, both directions, strap 2 -> device 3
    for (int r = 0; r < 64; r++) begin
      runFrame(3'd3, 6'(r), 1'b0, wrModel(6'(r), 0), 1'b0, 1'b1, 0, 1'b0, "R5");
      runFrame(3'd3, 6'(r), 1'b1, 16'h0, 1'b0, 1'b1, 0, 1'b0, "R3");
    end

    // R1 R7 R8: every strap against every device code
    for (int s = 0; s < 4; s++) begin
      strap = 2'(s);
      for (int d = 0; d < 8; d++) begin
        runFrame(3'(d), 6'h05, 1'b0, wrModel(6'h05, d), 1'b0, 1'b1, 0, 1'b0, "R1");
        runFrame(3'(d), 6'h05, 1'b1, 16'h0, 1'b0, 1'b1, 0, 1'b0, "R7");
      end
    end
    strap = 2'd1;

    // R4 R6: bad parity on write, zero ack from master on read
    runFrame(3'd2, 6'h09, 1'b0, 16'h1234, 1'b1, 1'b1, 0, 1'b0, "R4");
    runFrame(3'd2, 6'h04, 1'b0, 16'h00A5, 1'b1, 1'b1, 0, 1'b0, "R4");
    runFrame(3'd2, 6'h09, 1'b1, 16'h0, 1'b0, 1'b0, 0, 1'b0, "R6");

    // R7: broadcast write to a non-control register
    runFrame(3'd0, 6'h0A, 1'b0, 16'hFFFF, 1'b0, 1'b1, 0, 1'b0, "R7");

    // R9: start in the middle of a frame
    e0 = errCount;
    sendSym(3'd2);
    for (int i = 0; i < 5; i++) sendBit(1'b1, obs, sd, sb);
    check(errCount == e0, "R9", "error on abort", errCount - e0, 0);
    runFrame(3'd2, 6'h0C, 1'b0, 16'hBEEF, 1'b0, 1'b1, 0, 1'b0, "R9");

    // R10: reset symbol mid-frame, then bits that would finish a write
    w0 = wrCount; e0 = errCount;
    sendSym(3'd2);
    for (int i = 0; i < 6; i++) sendBit(i[0], obs, sd, sb);
    sendSym(3'd4);
    for (int i = 0; i < 30; i++) begin
      sendBit(1'b0, obs, sd, sb);
      check(sd == 0, "R10", "drive after reset symbol", int'(sd), 0);
    end
    check(wrCount == w0, "R10", "strobe after reset symbol", wrCount - w0, 0);
    check(errCount == e0, "R10", "error after reset symbol", errCount - e0, 0);
    runFrame(3'd2, 6'h11, 1'b0, 16'h5A5A, 1'b0, 1'b1, 0, 1'b0, "R10");

    // R11: surplus bits after the ack, and a long stall mid-frame
    w0 = wrCount; e0 = errCount;
    for (int i = 0; i < 6; i++) begin
      sendBit(1'b0, obs, sd, sb);
      check(sd == 0, "R11", "drive on surplus bit", int'(sd), 0);
    end
    check(wrCount == w0 && errCount == e0, "R11", "pulses on surplus bits",
          wrCount - w0 + errCount - e0, 0);
    runFrame(3'd2, 6'h13, 1'b0, 16'hC0DE, 1'b0, 1'b1, 3000, 1'b0, "R11");
    runFrame(3'd2, 6'h20, 1'b1, 16'h0, 1'b0, 1'b1, 3000, 1'b0, "R11");

    // R12: attention symbol between data bits
    runFrame(3'd2, 6'h15, 1'b0, 16'h8421, 1'b0, 1'b1, 0, 1'b1, "R12");
    runFrame(3'd2, 6'h15, 1'b1, 16'h0, 1'b0, 1'b1, 0, 1'b1, "R12");

    finishRun();
  end
endmodule